// File: doc/BRIEF.md
# Half-Overlap Windowed Frame Generator

This block is the streaming front end of a spectral analysis pipeline. It takes one signed sample on each cycle where the input valid is high and stores it in a circular history of N entries, where N is a power of two. It then emits frames of N samples with the oldest sample first. Consecutive frames share half their content: each frame reuses the newer half of the previous frame and adds N/2 fresh samples.

Every emitted sample is scaled by a window coefficient. The scaling uses a pipelined multiplier that accepts an operand on every cycle and has a fixed latency. A frame leaves the block as N consecutive valid cycles, with a marker on the first sample and a marker on the last. The history is held in a dual-port memory that returns the old contents when a location is read and written in the same cycle. Because of this, input can keep arriving at full rate while a frame is being read out. If a new frame becomes due while the previous frame is still being read, the block drops the new frame and pulses an overflow flag.

Top module: `wfg_frame_gen`

## Requirements
- R1: While `rst_ni` is low and on the first cycle after it rises, `frame_vld_o`, `frame_sof_o`, `frame_eof_o` and `ovf_o` are all 0.
- R2: No frame is emitted until N samples have been accepted. The first frame becomes due on the edge that accepts sample number N.
- R3: After the first frame, a further frame becomes due each time N/2 more samples have been accepted. A frame holds the N most recently accepted samples, oldest first, so each frame repeats the newer half of the previous one.
- R4: Output sample k of a frame (k = 0..N-1) equals (x * w(k)) arithmetically shifted right by COEF_FRAC and truncated to DATA_W bits. Here x is the stored sample and w(k) = (2*min(k, N-1-k) + 1) * 2^(COEF_FRAC - N_LOG2).
- R5: `frame_sof_o` is high in the cycle after the (MUL_LAT+1)-th rising edge that follows the edge accepting the sample that made the frame due.
- R6: A frame occupies exactly N consecutive cycles with `frame_vld_o` high. `frame_sof_o` is high only on the first of these cycles and `frame_eof_o` only on the last. Outside frames, `frame_vld_o` is 0.
- R7: If a frame becomes due at any edge from 1 to N-1 edges after the edge on which the frame currently being read became due, that new frame is dropped. In that case `ovf_o` is high for one cycle, starting after that edge. A frame that becomes due exactly N edges later is emitted normally.
- R8: Cycles with `sample_vld_i` low are ignored. No sample is stored and no count advances.
- R9: Samples accepted while a frame is being read out, including on every cycle, do not alter the contents of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Signed input sample |
| sample_vld_i | input | 1 | Input sample is valid this cycle |
| frame_o | output | DATA_W | Windowed output sample, signed |
| frame_vld_o | output | 1 | Output sample valid |
| frame_sof_o | output | 1 | First sample of a frame |
| frame_eof_o | output | 1 | Last sample of a frame |
| ovf_o | output | 1 | One-cycle pulse: a due frame was dropped |

## Verification
A write pointer that has drifted shows up in the first frame that follows: the samples come out rotated or stale. A wrong fill count moves `frame_sof_o` by N/2 samples. A miscounted read index breaks the N-cycle valid run, or puts the end marker on the wrong cycle, within one frame. A busy flag that clears late or early appears as a missing or extra `ovf_o` pulse at the triggering edge itself. The bench compares every output cycle against a frame queue built from the accepted inputs. Any such fault is therefore reported at the first cycle where it becomes visible.

// File: rtl/wfg_pkg.sv
package wfg_pkg;
  typedef struct packed {
    logic vld;
    logic sof;
    logic eof;
  } wfg_tag_t;
endpackage

// File: rtl/wfg_hist_ram.sv
module wfg_hist_ram #(
  parameter int AW = 4,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  // nonblocking write: a same-address read returns the old word
  always_ff @(posedge clk_i) begin
    if (re_i) rdata_o <= mem_q[raddr_i];
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
endmodule

// File: rtl/wfg_frame_ctrl.sv
module wfg_frame_ctrl #(
  parameter int N_LOG2 = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_vld_i,
  output logic              wr_en_o,
  output logic [N_LOG2-1:0] wr_addr_o,
  output logic              rd_en_o,
  output logic [N_LOG2-1:0] rd_addr_o,
  output logic [N_LOG2-1:0] rd_idx_o,
  output logic              rd_sof_o,
  output logic              rd_eof_o,
  output logic              ovf_o
);
  localparam int AW = N_LOG2;

  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_idx_q;
  logic          filled_q, busy_q, ovf_q;
  logic          trig, last, free;

  // wr_ptr doubles as sample count mod N
  assign trig = in_vld_i && (&wr_ptr_q[AW-2:0]) && (filled_q || (&wr_ptr_q));
  assign last = busy_q && (&rd_idx_q);
  assign free = !busy_q || last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      filled_q <= 1'b0;
    end else if (in_vld_i) begin
      wr_ptr_q <= wr_ptr_q + AW'(1);
      if (&wr_ptr_q) filled_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      rd_ptr_q <= '0;
      rd_idx_q <= '0;
      ovf_q    <= 1'b0;
    end else begin
      ovf_q <= trig && !free;
      if (trig && free) begin
        busy_q   <= 1'b1;
        rd_ptr_q <= wr_ptr_q + AW'(1);  // oldest entry once this write lands
        rd_idx_q <= '0;
      end else if (busy_q) begin
        rd_ptr_q <= rd_ptr_q + AW'(1);
        rd_idx_q <= rd_idx_q + AW'(1);
        if (last) busy_q <= 1'b0;
      end
    end
  end

  assign wr_en_o   = in_vld_i;
  assign wr_addr_o = wr_ptr_q;
  assign rd_en_o   = busy_q;
  assign rd_addr_o = rd_ptr_q;
  assign rd_idx_o  = rd_idx_q;
  assign rd_sof_o  = busy_q && (rd_idx_q == '0);
  assign rd_eof_o  = last;
  assign ovf_o     = ovf_q;

  p_rd_after_fill_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_o |-> filled_q);
  p_no_back_to_back_ovf_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |=> !ovf_o);
endmodule

// File: rtl/wfg_win_mul.sv
module wfg_win_mul #(
  parameter int N_LOG2    = 4,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int MUL_LAT   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  wfg_pkg::wfg_tag_t in_tag_i,
  input  logic [N_LOG2-1:0] in_idx_i,
  input  logic [DATA_W-1:0] in_data_i,
  output wfg_pkg::wfg_tag_t out_tag_o,
  output logic [DATA_W-1:0] out_data_o
);
  localparam int AW = N_LOG2;
  localparam int PW = DATA_W + COEF_W;
  localparam int SH = COEF_FRAC - N_LOG2;

  logic [AW-2:0]          mirror;
  logic [AW-1:0]          odd;
  logic [COEF_W-1:0]      coef;
  logic signed [PW-1:0]   a_ext, b_ext;
  logic signed [PW-1:0]   pr_q  [MUL_LAT];
  wfg_pkg::wfg_tag_t      tag_q [MUL_LAT];

  // triangular window: odd ramp mirrored about the midpoint
  assign mirror = in_idx_i[AW-1] ? ~in_idx_i[AW-2:0] : in_idx_i[AW-2:0];
  assign odd    = {mirror, 1'b1};
  assign coef   = COEF_W'(odd) << SH;
  assign a_ext  = PW'($signed(in_data_i));
  assign b_ext  = {{(PW-COEF_W){1'b0}}, coef};

  always_ff @(posedge clk_i) begin
    pr_q[0] <= a_ext * b_ext;
    for (int s = 1; s < MUL_LAT; s++) pr_q[s] <= pr_q[s-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < MUL_LAT; s++) tag_q[s] <= '0;
    end else begin
      tag_q[0] <= in_tag_i;
      for (int s = 1; s < MUL_LAT; s++) tag_q[s] <= tag_q[s-1];
    end
  end

  assign out_tag_o  = tag_q[MUL_LAT-1];
  assign out_data_o = DATA_W'(pr_q[MUL_LAT-1] >>> COEF_FRAC);

  p_out_sof_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_tag_o.sof |-> out_tag_o.vld);
  p_out_eof_vld_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_tag_o.eof |-> out_tag_o.vld);
endmodule

// File: rtl/wfg_frame_gen.sv
module wfg_frame_gen #(
  parameter int N_LOG2    = 4,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 14,
  parameter int MUL_LAT   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              sample_vld_i,
  output logic [DATA_W-1:0] frame_o,
  output logic              frame_vld_o,
  output logic              frame_sof_o,
  output logic              frame_eof_o,
  output logic              ovf_o
);
  localparam int AW = N_LOG2;

  logic              wr_en, rd_en, rd_sof, rd_eof;
  logic [AW-1:0]     wr_addr, rd_addr, rd_idx, s1_idx;
  logic [DATA_W-1:0] rd_data;
  wfg_pkg::wfg_tag_t s1_tag, out_tag;

  wfg_frame_ctrl #(.N_LOG2(N_LOG2)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .in_vld_i  (sample_vld_i),
    .wr_en_o   (wr_en),
    .wr_addr_o (wr_addr),
    .rd_en_o   (rd_en),
    .rd_addr_o (rd_addr),
    .rd_idx_o  (rd_idx),
    .rd_sof_o  (rd_sof),
    .rd_eof_o  (rd_eof),
    .ovf_o     (ovf_o)
  );

  wfg_hist_ram #(.AW(AW), .DW(DATA_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (wr_en),
    .waddr_i (wr_addr),
    .wdata_i (sample_i),
    .re_i    (rd_en),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  // align sideband with the registered RAM read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_tag <= '0;
      s1_idx <= '0;
    end else begin
      s1_tag <= '{vld: rd_en, sof: rd_sof, eof: rd_eof};
      s1_idx <= rd_idx;
    end
  end

  wfg_win_mul #(
    .N_LOG2    (N_LOG2),
    .DATA_W    (DATA_W),
    .COEF_W    (COEF_W),
    .COEF_FRAC (COEF_FRAC),
    .MUL_LAT   (MUL_LAT)
  ) u_mul (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .in_tag_i   (s1_tag),
    .in_idx_i   (s1_idx),
    .in_data_i  (rd_data),
    .out_tag_o  (out_tag),
    .out_data_o (frame_o)
  );

  assign frame_vld_o = out_tag.vld;
  assign frame_sof_o = out_tag.sof;
  assign frame_eof_o = out_tag.eof;

  p_frame_contig_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_vld_o && !frame_eof_o |=> frame_vld_o && !frame_sof_o);
  p_after_eof_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_eof_o |=> !frame_vld_o || frame_sof_o);
  p_sof_not_eof_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_sof_o |-> !frame_eof_o);
endmodule

// File: tb/wfg_frame_gen_tb.sv
module wfg_frame_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_LOG2 = 4;
  localparam int N      = 1 << N_LOG2;
  localparam int DW     = 16;
  localparam int CW     = 16;
  localparam int FRAC   = 14;
  localparam int LAT    = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [DW-1:0] sample_i = '0;
  logic          sample_vld_i = 1'b0;
  logic [DW-1:0] frame_o;
  logic          frame_vld_o, frame_sof_o, frame_eof_o, ovf_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  string phase = "R2";

  wfg_frame_gen #(.N_LOG2(N_LOG2), .DATA_W(DW), .COEF_W(CW),
                  .COEF_FRAC(FRAC), .MUL_LAT(LAT)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sample_i(sample_i), .sample_vld_i(sample_vld_i),
    .frame_o(frame_o), .frame_vld_o(frame_vld_o), .frame_sof_o(frame_sof_o),
    .frame_eof_o(frame_eof_o), .ovf_o(ovf_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  logic [DW-1:0] hist_q [$];
  int            total = 0;
  int            last_start = -1000000;
  int            exp_start_q [$];
  logic [DW-1:0] exp_dat_q [$];
  bit            exp_ovf [int];
  int            frames_exp = 0, frames_seen = 0, ovf_exp = 0, ovf_seen = 0;

  function automatic int coef_of(int k);
    int m;
    m = (k < N/2) ? k : N - 1 - k;
    return (2*m + 1) << (FRAC - N_LOG2);
  endfunction

  function automatic logic [DW-1:0] win_of(logic [DW-1:0] x, int k);
    longint p;
    p = longint'($signed(x)) * longint'(coef_of(k));
    return DW'(p >>> FRAC);
  endfunction

  always @(posedge clk) begin
    if (!rst_ni) cyc = 0;
    else begin
      cyc++;
      if (sample_vld_i) begin
        hist_q.push_back(sample_i);
        if (hist_q.size() > N) void'(hist_q.pop_front());
        total++;
        if (total == N || (total > N && (total - N) % (N/2) == 0)) begin
          if (cyc < last_start + N) begin
            exp_ovf[cyc] = 1'b1;
            ovf_exp++;
          end else begin
            last_start = cyc;
            exp_start_q.push_back(cyc + LAT + 1);
            for (int k = 0; k < N; k++) exp_dat_q.push_back(win_of(hist_q[k], k));
            frames_exp++;
          end
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  // ---------------- output checker ----------------
  always @(negedge clk) begin
    if (rst_ni && cyc > 0) begin
      bit in_frame;
      int idx;
      in_frame = exp_start_q.size() > 0 && cyc >= exp_start_q[0];
      idx = in_frame ? cyc - exp_start_q[0] : 0;
      check(frame_vld_o == in_frame, (frames_exp == 0) ? "R2 valid" : "R6 valid",
            int'(frame_vld_o), int'(in_frame));
      check(frame_sof_o == (in_frame && idx == 0), "R5 sof timing",
            int'(frame_sof_o), int'(in_frame && idx == 0));
      check(frame_eof_o == (in_frame && idx == N-1), "R6 eof",
            int'(frame_eof_o), int'(in_frame && idx == N-1));
      check(ovf_o == exp_ovf.exists(cyc), "R7 ovf", int'(ovf_o), int'(exp_ovf.exists(cyc)));
      if (ovf_o) ovf_seen++;
      if (in_frame) begin
        check(frame_o == exp_dat_q[idx], {"R3/R4 data ", phase},
              int'($signed(frame_o)), int'($signed(exp_dat_q[idx])));
        if (idx == N-1) begin
          void'(exp_start_q.pop_front());
          for (int k = 0; k < N; k++) void'(exp_dat_q.pop_front());
          frames_seen++;
        end
      end
    end
  end

  task automatic drive(bit v, logic [DW-1:0] d);
    @(negedge clk);
    sample_vld_i = v;
    sample_i = d;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int unused;
    unused = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    check(!frame_vld_o && !frame_sof_o && !frame_eof_o && !ovf_o, "R1 in reset",
          int'({frame_vld_o, frame_sof_o, frame_eof_o, ovf_o}), 0);
    @(negedge clk) rst_ni = 1'b1;
    @(negedge clk);
    check(!frame_vld_o && !frame_sof_o && !frame_eof_o && !ovf_o, "R1 after reset",
          int'({frame_vld_o, frame_sof_o, frame_eof_o, ovf_o}), 0);

    // R2: directed fill, ramp values, one short of a frame then idle
    phase = "R2";
    for (int i = 0; i < N-1; i++) drive(1'b1, DW'(i * 100 - 700));
    repeat (2*N) drive(1'b0, 16'hdead);
    drive(1'b1, 16'h0123);
    repeat (N + LAT + 4) drive(1'b0, '0);

    // R8: sparse random input with garbage on idle cycles
    phase = "R8";
    for (int i = 0; i < 6*N; i++) begin
      while ($urandom % 3 == 0) drive(1'b0, DW'($urandom));
      drive(1'b1, DW'($urandom));
      drive(1'b0, DW'($urandom));
    end
    repeat (2*N) drive(1'b0, '0);

    // R9 and R7: full rate, writes land during readout and frames collide
    phase = "R9";
    for (int i = 0; i < 8*N; i++) drive(1'b1, DW'($urandom));
    repeat (2*N) drive(1'b0, '0);

    // R4: extreme magnitudes, one sample every third cycle
    phase = "R4";
    for (int i = 0; i < 4*N; i++) begin
      drive(1'b1, (i % 2 == 0) ? 16'h7fff : 16'h8000);
      drive(1'b0, '0);
      drive(1'b0, '0);
    end
    repeat (2*N + LAT + 4) drive(1'b0, '0);

    check(frames_seen == frames_exp, "R3 frame count", frames_seen, frames_exp);
    check(ovf_seen == ovf_exp && ovf_exp > 0, "R7 overflow count", ovf_seen, ovf_exp);
    check(exp_start_q.size() == 0, "R6 drained", exp_start_q.size(), 0);
    finish_run();
  end
endmodule